// File: doc/BRIEF.md
# Serial Slave Output Port

This block sends complex output words (an I part and a Q part) from a processing core to an external reader. The reader owns the serial clock. The core side offers each new word on a valid/ready stream. The port keeps the word in a holding register and raises a data-valid strobe toward the reader. The strobe is 2 core clocks wide in single-channel mode and 4 core clocks wide in dual-channel mode.

The reader answers with a frame-sync pulse on its own clock. The port then shifts out the I part and then the Q part, each most significant bit first. Each bit changes on a rising edge of the serial clock so that the reader can sample it on the falling edge. An end-of-frame flag marks the last bit, for readers that do not count bits.

The serial clock may be unrelated to the core clock. A toggle handshake with two-flop synchronisers carries word arrival and frame completion across the two clock domains. The only rule is that the reader must finish a frame before the next word arrives.

The stream input applies no back-pressure. `in_ready` rises one core clock after reset and then stays high, so every `in_valid` cycle delivers a word. A word that arrives while the previous word has not been fully read is still accepted. It raises a sticky overrun flag, and the frame already on the wire is left intact.

Top module: `serial_slave_out`

## Requirements
- R1: Out of reset `in_ready` goes high and stays high. Every core cycle with `in_valid` high captures `in_i` and `in_q` as the current word.
- R2: `dv_out` goes high in the core cycle after a word is accepted. It stays high for exactly 2 core cycles when `dual_mode` is 0 and exactly 4 when `dual_mode` is 1.
- R3: If `sdfs` is sampled high on a rising `sclk` edge while the port is idle, the next rising `sclk` edge drives the most significant bit of the I part onto `sdo`.
- R4: After the first bit, each rising `sclk` edge presents the next bit. The order is the upper `word_len` bits of the I part, most significant bit first, followed by the upper `word_len` bits of the Q part in the same order.
- R5: `word_len` gives the number of bits per part, from 1 to DATA_W. The value 0, or any value above DATA_W, means DATA_W. A frame carries twice that many bits.
- R6: `sdfe` is high for exactly one `sclk` period, the period in which the final bit of the frame is on `sdo`.
- R7: Between frames `sdo` and `sdfe` are 0. Without a frame-sync, no bits are shifted out, even if a word is waiting.
- R8: Accepting a word before the frame of the previous word has completed sets `overrun`. Only reset clears it. The frame in progress still carries the earlier word unchanged.
- R9: A frame carries the most recently accepted word at the moment the frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset for both clock domains |
| in_valid | input | 1 | Core word valid |
| in_ready | output | 1 | Port ready; high whenever out of reset |
| in_i | input | DATA_W | I part of the word |
| in_q | input | DATA_W | Q part of the word |
| word_len | input | LEN_W | Bits per part; 0 or above DATA_W selects DATA_W |
| dual_mode | input | 1 | 0: 2-cycle data-valid pulse, 1: 4-cycle pulse |
| dv_out | output | 1 | New-word strobe to the reader |
| overrun | output | 1 | Sticky: a word arrived before the previous frame finished |
| sclk | input | 1 | Serial clock from the external reader |
| sdfs | input | 1 | Frame-sync from the reader, synchronous to sclk |
| sdo | output | 1 | Serial data, changes on rising sclk |
| sdfe | output | 1 | End-of-frame flag, high during the final bit |

## Verification
The bench aims at the frame boundaries: the single-bit-per-part length and the out-of-range length codes. A sequencer that counts off by one would drop or repeat a bit, or would raise `sdfe` one period early or late. It also leaves a word waiting without any frame-sync. A port that starts shifting by itself would show bits on `sdo`. Finally, it delivers a second word in the middle of a frame. A design that shifts straight from the holding register would corrupt the bits already on the wire, and one that loses the handshake state would show no overrun or would send the old word twice.

// File: rtl/sso_pkg.sv
`timescale 1ns/1ps
package sso_pkg;
  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_ARMED = 2'd1,
    SH_SHIFT = 2'd2
  } sh_state_e;
endpackage

// File: rtl/sso_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser for a single slowly changing level.
module sso_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= '0;
        else        ff <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= '0;
        else        ff <= {ff[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = ff[STAGES-1];
endmodule

// File: rtl/sso_capture.sv
`timescale 1ns/1ps
// Core-domain side: word capture, new-word strobe, request toggle, overrun.
module sso_capture #(
  parameter int DATA_W    = 16,
  parameter int DV_SINGLE = 2,
  parameter int DV_DUAL   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_i,
  input  logic [DATA_W-1:0] in_q,
  input  logic              dual_mode,
  input  logic              done_sync,
  output logic [DATA_W-1:0] hold_i,
  output logic [DATA_W-1:0] hold_q,
  output logic              req_tog,
  output logic              dv_out,
  output logic              overrun
);
  localparam int DV_MAX = (DV_DUAL > DV_SINGLE) ? DV_DUAL : DV_SINGLE;
  localparam int DV_CW  = $clog2(DV_MAX + 1);

  logic             ready_r;
  logic             accept;
  logic [DV_CW-1:0] dv_cnt;

  assign accept   = in_valid & ready_r;
  assign in_ready = ready_r;
  assign dv_out   = (dv_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_r <= 1'b0;
      hold_i  <= '0;
      hold_q  <= '0;
      req_tog <= 1'b0;
      overrun <= 1'b0;
    end else begin
      ready_r <= 1'b1;
      if (accept) begin
        hold_i  <= in_i;
        hold_q  <= in_q;
        req_tog <= ~req_tog;
        if (req_tog != done_sync) overrun <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dv_cnt <= '0;
    else if (accept)     dv_cnt <= dual_mode ? DV_CW'(DV_DUAL) : DV_CW'(DV_SINGLE);
    else if (dv_out)     dv_cnt <= dv_cnt - 1'b1;
  end
endmodule

// File: rtl/sso_shifter.sv
`timescale 1ns/1ps
// Serial-clock side: frame sequencer and output shift registers.
module sso_shifter
  import sso_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              sdfs,
  input  logic [DATA_W-1:0] hold_i,
  input  logic [DATA_W-1:0] hold_q,
  input  logic [LEN_W-1:0]  word_len,
  input  logic              req_sync,
  output logic              sdo,
  output logic              sdfe,
  output logic              done_tog,
  output logic              busy
);
  localparam int CNT_W = $clog2(2 * DATA_W + 1);

  sh_state_e         state;
  logic [DATA_W-1:0] sh_i, sh_q;
  logic [CNT_W-1:0]  cnt, len_r, len2_r, eff_len, cnt_nx;
  logic              taken;

  always_comb begin
    if (word_len == '0 || word_len > LEN_W'(DATA_W)) eff_len = CNT_W'(DATA_W);
    else                                             eff_len = CNT_W'(word_len);
  end

  assign cnt_nx = cnt + 1'b1;
  assign busy   = (state != SH_IDLE);

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SH_IDLE;
      sh_i     <= '0;
      sh_q     <= '0;
      cnt      <= '0;
      len_r    <= '0;
      len2_r   <= '0;
      sdo      <= 1'b0;
      sdfe     <= 1'b0;
      taken    <= 1'b0;
      done_tog <= 1'b0;
    end else begin
      unique case (state)
        SH_IDLE: begin
          sdo  <= 1'b0;
          sdfe <= 1'b0;
          if (sdfs) state <= SH_ARMED;
        end
        SH_ARMED: begin
          sh_i   <= hold_i << 1;
          sh_q   <= hold_q;
          sdo    <= hold_i[DATA_W-1];
          sdfe   <= 1'b0;
          cnt    <= CNT_W'(1);
          len_r  <= eff_len;
          len2_r <= eff_len << 1;
          taken  <= req_sync;
          state  <= SH_SHIFT;
        end
        SH_SHIFT: begin
          if (cnt == len2_r) begin
            sdo      <= 1'b0;
            sdfe     <= 1'b0;
            done_tog <= taken;
            state    <= sdfs ? SH_ARMED : SH_IDLE;
          end else begin
            if (cnt < len_r) begin
              sdo  <= sh_i[DATA_W-1];
              sh_i <= sh_i << 1;
            end else begin
              sdo  <= sh_q[DATA_W-1];
              sh_q <= sh_q << 1;
            end
            cnt  <= cnt_nx;
            sdfe <= (cnt_nx == len2_r);
          end
        end
        default: state <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_slave_out.sv
`timescale 1ns/1ps
module serial_slave_out #(
  parameter int DATA_W    = 16,
  parameter int LEN_W     = $clog2(DATA_W + 1),
  parameter int DV_SINGLE = 2,
  parameter int DV_DUAL   = 4,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_i,
  input  logic [DATA_W-1:0] in_q,
  input  logic [LEN_W-1:0]  word_len,
  input  logic              dual_mode,
  output logic              dv_out,
  output logic              overrun,
  input  logic              sclk,
  input  logic              sdfs,
  output logic              sdo,
  output logic              sdfe
);
  logic [DATA_W-1:0] hold_i, hold_q;
  logic              req_tog, req_sync, done_tog, done_sync, shift_busy;

  sso_capture #(
    .DATA_W(DATA_W), .DV_SINGLE(DV_SINGLE), .DV_DUAL(DV_DUAL)
  ) u_capture (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .dual_mode(dual_mode), .done_sync(done_sync),
    .hold_i(hold_i), .hold_q(hold_q), .req_tog(req_tog),
    .dv_out(dv_out), .overrun(overrun)
  );

  sso_sync #(.STAGES(SYNC_STG)) u_req_sync (
    .clk(sclk), .rst_n(rst_n), .d(req_tog), .q(req_sync)
  );

  sso_sync #(.STAGES(SYNC_STG)) u_done_sync (
    .clk(clk), .rst_n(rst_n), .d(done_tog), .q(done_sync)
  );

  sso_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shifter (
    .sclk(sclk), .rst_n(rst_n), .sdfs(sdfs), .hold_i(hold_i), .hold_q(hold_q),
    .word_len(word_len), .req_sync(req_sync), .sdo(sdo), .sdfe(sdfe),
    .done_tog(done_tog), .busy(shift_busy)
  );
endmodule

// File: rtl/sso_checker.sv
`timescale 1ns/1ps
module sso_checker #(
  parameter int DV_SINGLE = 2,
  parameter int DV_DUAL   = 4
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic dual_mode,
  input logic dv_out,
  input logic overrun,
  input logic sclk,
  input logic sdo,
  input logic sdfe,
  input logic shift_busy
);
  logic [3:0] dv_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 dv_run <= '0;
    else if (in_valid && in_ready) dv_run <= '0;
    else if (dv_out && dv_run != 4'hF) dv_run <= dv_run + 1'b1;
    else if (!dv_out)           dv_run <= '0;
  end

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_ready) |-> in_ready); // R1
  AST_DV_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> dv_out); // R2
  AST_DV_WIDTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    dv_out |-> (int'(dv_run) < (dual_mode ? DV_DUAL : DV_SINGLE))); // R2
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R8
  AST_SDFE_ONE_PERIOD: assert property (@(posedge sclk) disable iff (!rst_n)
    sdfe |=> !sdfe); // R6
  AST_SDFE_IN_FRAME: assert property (@(posedge sclk) disable iff (!rst_n)
    sdfe |-> shift_busy); // R6
  AST_IDLE_QUIET: assert property (@(posedge sclk) disable iff (!rst_n)
    !shift_busy |-> (!sdo && !sdfe)); // R7
endmodule

bind serial_slave_out sso_checker #(.DV_SINGLE(DV_SINGLE), .DV_DUAL(DV_DUAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .dual_mode(dual_mode), .dv_out(dv_out), .overrun(overrun), .sclk(sclk),
  .sdo(sdo), .sdfe(sdfe), .shift_busy(shift_busy)
);

// File: tb/serial_slave_out_tb.sv
`timescale 1ns/1ps
module serial_slave_out_tb;
  localparam int DW = 16;
  localparam int LW = 5;

  logic clk = 0, sclk = 0, rst_n = 0;
  logic in_valid = 0, dual_mode = 0, sdfs = 0;
  logic [DW-1:0] in_i = '0, in_q = '0;
  logic [LW-1:0] word_len = '0;
  logic in_ready, dv_out, overrun, sdo, sdfe;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  typedef struct { logic [DW-1:0] i; logic [DW-1:0] q; int len; } item_t;
  item_t exp_q[$];

  serial_slave_out u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_i(in_i), .in_q(in_q), .word_len(word_len), .dual_mode(dual_mode),
    .dv_out(dv_out), .overrun(overrun), .sclk(sclk), .sdfs(sdfs),
    .sdo(sdo), .sdfe(sdfe)
  );

  always #4 clk = ~clk;
  initial begin #3; forever #15 sclk = ~sclk; end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff_len(input int wl);
    return (wl == 0 || wl > DW) ? DW : wl;
  endfunction

  // Driver: offers one word, queues the expected frame, measures the strobe.
  task automatic push(input logic [DW-1:0] wi, input logic [DW-1:0] wq);
    item_t it;
    int width;
    it.i = wi; it.q = wq; it.len = eff_len(int'(word_len));
    exp_q.push_back(it);
    @(negedge clk);
    in_valid = 1; in_i = wi; in_q = wq;
    @(negedge clk);
    in_valid = 0;
    width = 0;
    while (dv_out && width < 20) begin width++; @(negedge clk); end
    check(width == (dual_mode ? 4 : 2), "R2 dv width", width, dual_mode ? 4 : 2);
  endtask

  // Monitor: issues a frame-sync, pops the expected item and compares each bit.
  task automatic read_frame(input string tag);
    item_t it;
    int n, errs, fe_errs;
    logic expb;
    it = exp_q.pop_front();
    n = 2 * it.len;
    errs = 0; fe_errs = 0;
    repeat (3) @(negedge sclk);
    sdfs = 1;
    @(negedge sclk);
    sdfs = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge sclk);
      expb = (k < it.len) ? it.i[DW-1-k] : it.q[DW-1-(k-it.len)];
      if (sdo !== expb) errs++;
      if (sdfe !== (k == n - 1)) fe_errs++;
    end
    check(errs == 0, {tag, " R3 R4 frame bits"}, errs, 0);
    check(fe_errs == 0, "R6 sdfe on final bit only", fe_errs, 0);
    @(negedge sclk);
    check(sdo == 0 && sdfe == 0, "R7 quiet after frame", {sdo, sdfe}, 0);
    repeat (4) @(negedge sclk);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    word_len = 5'd16;
    #40;
    check(dv_out == 0 && sdo == 0 && sdfe == 0 && overrun == 0,
          "R7 reset state", {dv_out, sdo, sdfe, overrun}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(in_ready == 1, "R1 ready after reset", in_ready, 1);

    // Full length, single mode
    push(16'hA5C3, 16'h1E0F);
    read_frame("R4 full");
    dual_mode = 1;
    push(16'h8001, 16'h7FFE);
    read_frame("R4 dual");
    dual_mode = 0;
    check(overrun == 0, "R8 no overrun on paced words", overrun, 0);

    // Length variants
    word_len = 5'd8;  push(16'hF00F, 16'h3CC3); read_frame("R5 len8");
    word_len = 5'd1;  push(16'h8000, 16'h0000); read_frame("R5 len1a");
    word_len = 5'd1;  push(16'h7FFF, 16'hFFFF); read_frame("R5 len1b");
    word_len = 5'd0;  push(16'h1234, 16'hABCD); read_frame("R5 len0");
    word_len = 5'd20; push(16'hCAFE, 16'h0BEE); read_frame("R5 len20");
    word_len = 5'd16;

    // No frame-sync: nothing leaves the port
    push(16'hFFFF, 16'hFFFF);
    begin
      int seen = 0;
      repeat (12) begin @(negedge sclk); if (sdo || sdfe) seen++; end
      check(seen == 0, "R7 no shift without sync", seen, 0);
    end
    read_frame("R7 late read");
    check(overrun == 0, "R8 still clear", overrun, 0);

    // Word arriving mid-frame
    push(16'h9669, 16'h5AA5);
    fork
      read_frame("R8 intact frame");
      begin
        repeat (8) @(negedge sclk);
        push(16'h0F0F, 16'hF0F0);
        check(overrun == 1, "R8 overrun set", overrun, 1);
      end
    join
    read_frame("R9 newest word");
    check(overrun == 1, "R8 overrun sticky", overrun, 1);
    check(in_ready == 1, "R1 ready held", in_ready, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule